// File: doc/BRIEF.md
# Dual TAP Pin Selector

This block lets two internal test access port (TAP) controllers share one set of JTAG pins. One controller serves emulation and debug. The other serves boundary scan. Only one of them is wired to the pins at a time.

A select pin chooses between them. The value on that pin is captured at the instant the JTAG reset line rises. From then on it stays fixed until the reset line rises again, whatever the pin does in between. The connected controller receives the test reset, mode select and data input straight from the pins. The data output is taken from the connected controller only. The controller that is not connected is held in reset with its mode select tied high, so it never leaves Test-Logic-Reset.

The data output driver is enabled only while the connected controller is shifting. While the reset line is low, both controllers are held in reset and the output is not driven. On the board the select pin carries a pull-up, so emulation is chosen unless the pin is actively pulled low.

Top module: `dual_tap_pin_selector`

## Requirements
- R1: At most one TAP index is connected at any time. Every TAP that is not connected sees `tapTrstN` = 0, `tapTms` = 1 and `tapTdi` = 1, so it stays in Test-Logic-Reset while the pins toggle.
- R2: The value of `tapSelPin` is captured on the rising edge of `jtagTrstN`. TAP index i is connected when the captured value equals i. Index 0 is the boundary-scan TAP and index 1 is the emulation TAP. Only the value present at the rising edge counts, not values the pin held earlier while `jtagTrstN` was low.
- R3: A select pin at its idle high level (all ones, its pulled-up state) at the rising edge connects the emulation TAP (index 1).
- R4: A change on `tapSelPin` after the rising edge of `jtagTrstN` leaves the connected TAP unchanged until the next rising edge.
- R5: Every TAP receives `jtagTck` on its `tapTck` bit. The connected TAP receives `jtagTrstN`, `jtagTms` and `jtagTdi` unregistered on its `tapTrstN`, `tapTms` and `tapTdi` bits.
- R6: `jtagTdo` follows the `tapTdo` of the connected TAP. `jtagTdoEn` follows the `tapShift` of the connected TAP, which the TAP raises only in Shift-DR or Shift-IR.
- R7: While `jtagTrstN` is low, every bit of `tapTrstN` is low and `jtagTdoEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| jtagTrstN | input | 1 | JTAG test reset pin, active low; its rising edge captures the select |
| jtagTck | input | 1 | JTAG test clock pin |
| jtagTms | input | 1 | JTAG mode select pin |
| jtagTdi | input | 1 | JTAG serial data input pin |
| tapSelPin | input | SEL_W | TAP select pin (pulled up on the board) |
| jtagTdo | output | 1 | JTAG serial data output |
| jtagTdoEn | output | 1 | Output enable for the TDO pad driver |
| tapTck | output | NUM_TAPS | Test clock to each TAP |
| tapTrstN | output | NUM_TAPS | Test reset to each TAP, active low |
| tapTms | output | NUM_TAPS | Mode select to each TAP |
| tapTdi | output | NUM_TAPS | Serial data to each TAP |
| tapTdo | input | NUM_TAPS | Serial data from each TAP |
| tapShift | input | NUM_TAPS | High while that TAP is in Shift-DR or Shift-IR |

## Verification
The bench builds the block with its defaults: NUM_TAPS = 2, which gives a one-bit select. That makes both select values reachable, and the pulled-up all-ones level coincides with the emulation index. Two stub TAP state machines with different identification codes sit on the TAP side. Reading the code back through the shared pins therefore shows which controller is actually connected. The unselected stub's Test-Logic-Reset state shows that it ignored the TMS traffic.

// File: rtl/dtps_pkg.sv
`timescale 1ns/1ps
package dtps_pkg;
  // Widest select the strobe struct can carry; NUM_TAPS must fit in it.
  localparam int unsigned MaxSelW = 4;

  // Strobes from control to routing.
  typedef struct packed {
    logic                 sessionOn; // TRST released, a TAP may be connected
    logic [MaxSelW-1:0]   selIdx;    // TAP index captured at the TRST rise
  } dtps_strobe_t;
endpackage

// File: rtl/dtps_ctrl.sv
`timescale 1ns/1ps
module dtps_ctrl
  import dtps_pkg::*;
#(
  parameter int unsigned SEL_W = 1
) (
  input  logic             jtagTrstN,
  input  logic [SEL_W-1:0] tapSelPin,
  output dtps_strobe_t     strobe
);

  // The select is captured only at the rising edge of the test reset
  // and ignored at every other moment.
  logic [SEL_W-1:0] capturedSel;

  always_ff @(posedge jtagTrstN) begin
    capturedSel <= tapSelPin;
  end

  always_comb begin
    strobe.sessionOn = jtagTrstN;
    strobe.selIdx    = MaxSelW'(capturedSel);
  end

endmodule

// File: rtl/dtps_route.sv
`timescale 1ns/1ps
module dtps_route
  import dtps_pkg::*;
#(
  parameter int unsigned NUM_TAPS = 2
) (
  input  dtps_strobe_t          strobe,
  input  logic                  jtagTck,
  input  logic                  jtagTms,
  input  logic                  jtagTdi,
  output logic [NUM_TAPS-1:0]   tapTck,
  output logic [NUM_TAPS-1:0]   tapTrstN,
  output logic [NUM_TAPS-1:0]   tapTms,
  output logic [NUM_TAPS-1:0]   tapTdi,
  input  logic [NUM_TAPS-1:0]   tapTdo,
  input  logic [NUM_TAPS-1:0]   tapShift,
  output logic                  jtagTdo,
  output logic                  jtagTdoEn
);

  logic [NUM_TAPS-1:0] tapLive;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : gTap
    assign tapLive[i]  = strobe.sessionOn && (strobe.selIdx == MaxSelW'(i));
    assign tapTck[i]   = jtagTck;
    // A parked TAP sits in reset with TMS high.
    assign tapTrstN[i] = tapLive[i];
    assign tapTms[i]   = tapLive[i] ? jtagTms : 1'b1;
    assign tapTdi[i]   = tapLive[i] ? jtagTdi : 1'b1;
  end

  // At most one bit of tapLive is set, so an AND-OR acts as the mux.
  assign jtagTdo   = |(tapTdo & tapLive);
  assign jtagTdoEn = |(tapShift & tapLive);

endmodule

// File: rtl/dual_tap_pin_selector.sv
`timescale 1ns/1ps
module dual_tap_pin_selector
  import dtps_pkg::*;
#(
  parameter  int unsigned NUM_TAPS = 2,
  localparam int unsigned SEL_W    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
  input  logic                jtagTrstN,
  input  logic                jtagTck,
  input  logic                jtagTms,
  input  logic                jtagTdi,
  input  logic [SEL_W-1:0]    tapSelPin,
  output logic                jtagTdo,
  output logic                jtagTdoEn,
  output logic [NUM_TAPS-1:0] tapTck,
  output logic [NUM_TAPS-1:0] tapTrstN,
  output logic [NUM_TAPS-1:0] tapTms,
  output logic [NUM_TAPS-1:0] tapTdi,
  input  logic [NUM_TAPS-1:0] tapTdo,
  input  logic [NUM_TAPS-1:0] tapShift
);

  dtps_strobe_t strobe;

  dtps_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .jtagTrstN (jtagTrstN),
    .tapSelPin (tapSelPin),
    .strobe    (strobe)
  );

  dtps_route #(.NUM_TAPS(NUM_TAPS)) uRoute (
    .strobe    (strobe),
    .jtagTck   (jtagTck),
    .jtagTms   (jtagTms),
    .jtagTdi   (jtagTdi),
    .tapTck    (tapTck),
    .tapTrstN  (tapTrstN),
    .tapTms    (tapTms),
    .tapTdi    (tapTdi),
    .tapTdo    (tapTdo),
    .tapShift  (tapShift),
    .jtagTdo   (jtagTdo),
    .jtagTdoEn (jtagTdoEn)
  );

endmodule

// File: rtl/dtps_checker.sv
`timescale 1ns/1ps
module dtps_checker #(
  parameter int unsigned NUM_TAPS = 2
) (
  input logic                jtagTrstN,
  input logic                jtagTck,
  input logic                jtagTms,
  input logic                jtagTdi,
  input logic                jtagTdo,
  input logic                jtagTdoEn,
  input logic [NUM_TAPS-1:0] tapTrstN,
  input logic [NUM_TAPS-1:0] tapTms,
  input logic [NUM_TAPS-1:0] tapTdi,
  input logic [NUM_TAPS-1:0] tapTdo,
  input logic [NUM_TAPS-1:0] tapShift
);

  assert_one_connected_R1: assert property (@(posedge jtagTck) disable iff (!jtagTrstN)
    $onehot0(tapTrstN));

  assert_parked_in_reset_R1: assert property (@(posedge jtagTck) disable iff (!jtagTrstN)
    (tapTms | tapTrstN) == '1 && (tapTdi | tapTrstN) == '1);

  assert_selection_held_R4: assert property (@(posedge jtagTck) disable iff (!jtagTrstN)
    $past(jtagTrstN) |-> $stable(tapTrstN));

  for (genvar i = 0; i < NUM_TAPS; i++) begin : gChk
    assert_pins_pass_R5: assert property (@(posedge jtagTck) disable iff (!jtagTrstN)
      tapTrstN[i] |-> (tapTms[i] == jtagTms && tapTdi[i] == jtagTdi));

    assert_tdo_follows_R6: assert property (@(posedge jtagTck) disable iff (!jtagTrstN)
      (tapTrstN[i] && tapShift[i]) |-> (jtagTdoEn && jtagTdo == tapTdo[i]));
  end

  assert_tdo_en_source_R6: assert property (@(posedge jtagTck) disable iff (!jtagTrstN)
    jtagTdoEn |-> |(tapShift & tapTrstN));

  always_comb begin
    if (!jtagTrstN) begin
      assert_reset_quiet_R7: assert (tapTrstN == '0 && !jtagTdoEn);
    end
  end

endmodule

bind dual_tap_pin_selector dtps_checker #(.NUM_TAPS(NUM_TAPS)) uChk (
  .jtagTrstN (jtagTrstN),
  .jtagTck   (jtagTck),
  .jtagTms   (jtagTms),
  .jtagTdi   (jtagTdi),
  .jtagTdo   (jtagTdo),
  .jtagTdoEn (jtagTdoEn),
  .tapTrstN  (tapTrstN),
  .tapTms    (tapTms),
  .tapTdi    (tapTdi),
  .tapTdo    (tapTdo),
  .tapShift  (tapShift)
);

// File: tb/tb_dual_tap_pin_selector.sv
`timescale 1ns/1ps
module tb_tap_stub #(
  parameter logic [31:0] ID = 32'h0000_0001
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic shiftOn,
  output logic inReset
);
  typedef enum logic [3:0] {
    TLR, RTI, SELDR, CAPDR, SHDR, EX1DR, PADR, EX2DR, UPDR,
    SELIR, CAPIR, SHIR, EX1IR, PAIR, EX2IR, UPIR
  } st_t;

  st_t st, nx;
  logic [31:0] dr;
  logic [3:0]  ir;

  always_comb begin
    case (st)
      TLR:   nx = tms ? TLR   : RTI;
      RTI:   nx = tms ? SELDR : RTI;
      SELDR: nx = tms ? SELIR : CAPDR;
      CAPDR: nx = tms ? EX1DR : SHDR;
      SHDR:  nx = tms ? EX1DR : SHDR;
      EX1DR: nx = tms ? UPDR  : PADR;
      PADR:  nx = tms ? EX2DR : PADR;
      EX2DR: nx = tms ? UPDR  : SHDR;
      UPDR:  nx = tms ? SELDR : RTI;
      SELIR: nx = tms ? TLR   : CAPIR;
      CAPIR: nx = tms ? EX1IR : SHIR;
      SHIR:  nx = tms ? EX1IR : SHIR;
      EX1IR: nx = tms ? UPIR  : PAIR;
      PAIR:  nx = tms ? EX2IR : PAIR;
      EX2IR: nx = tms ? UPIR  : SHIR;
      default: nx = tms ? SELDR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      st <= TLR;
      dr <= ID;
      ir <= 4'b0101;
    end else begin
      st <= nx;
      if (st == CAPDR) dr <= ID;
      else if (st == SHDR) dr <= {tdi, dr[31:1]};
      if (st == CAPIR) ir <= 4'b0101;
      else if (st == SHIR) ir <= {tdi, ir[3:1]};
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdo <= 1'b0;
    else        tdo <= (st == SHIR) ? ir[0] : dr[0];
  end

  assign shiftOn = (st == SHDR) || (st == SHIR);
  assign inReset = (st == TLR);
endmodule

module tb_dual_tap_pin_selector;
  localparam logic [31:0] BSC_ID = 32'h0B5C_A11D;
  localparam logic [31:0] EMU_ID = 32'h4E31_7A2F;

  logic jtagTrstN, jtagTck, jtagTms, jtagTdi;
  logic [0:0] tapSelPin;
  logic jtagTdo, jtagTdoEn;
  logic [1:0] tapTck, tapTrstN, tapTms, tapTdi;
  wire  [1:0] tapTdo, tapShift, tapInReset;

  int checks = 0;
  int errors = 0;
  logic sTdo, sEn;

  typedef struct { logic [31:0] id; string tag; } exp_t;
  exp_t expQ[$];
  logic [31:0] gotWord;
  logic gotEnAll;
  event wordEv;

  dual_tap_pin_selector #(.NUM_TAPS(2)) dut (
    .jtagTrstN (jtagTrstN), .jtagTck (jtagTck), .jtagTms (jtagTms), .jtagTdi (jtagTdi),
    .tapSelPin (tapSelPin), .jtagTdo (jtagTdo), .jtagTdoEn (jtagTdoEn),
    .tapTck (tapTck), .tapTrstN (tapTrstN), .tapTms (tapTms), .tapTdi (tapTdi),
    .tapTdo (tapTdo), .tapShift (tapShift)
  );

  tb_tap_stub #(.ID(BSC_ID)) uBsc (
    .tck (tapTck[0]), .trstN (tapTrstN[0]), .tms (tapTms[0]), .tdi (tapTdi[0]),
    .tdo (tapTdo[0]), .shiftOn (tapShift[0]), .inReset (tapInReset[0]));

  tb_tap_stub #(.ID(EMU_ID)) uEmu (
    .tck (tapTck[1]), .trstN (tapTrstN[1]), .tms (tapTms[1]), .tdi (tapTdi[1]),
    .tdo (tapTdo[1]), .shiftOn (tapShift[1]), .inReset (tapInReset[1]));

  initial jtagTck = 1'b0;
  always #2.5 jtagTck = ~jtagTck;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Sample outputs after the falling edge, then drive TMS/TDI for the next rise.
  task automatic step(input logic tms, input logic tdi);
    @(negedge jtagTck);
    #1;
    sTdo = jtagTdo;
    sEn  = jtagTdoEn;
    jtagTms = tms;
    jtagTdi = tdi;
    @(posedge jtagTck);
    #1;
  endtask

  // Driver: push the expected code, then shift the data register out.
  task automatic readId(input logic [31:0] expId, input string tag);
    logic [31:0] w;
    logic enAll;
    exp_t e;
    e.id = expId;
    e.tag = tag;
    expQ.push_back(e);
    step(1'b0, 1'b0);   // to Run-Test/Idle
    step(1'b1, 1'b0);   // Select-DR
    step(1'b0, 1'b0);   // Capture-DR
    step(1'b0, 1'b0);   // Shift-DR
    enAll = 1'b1;
    for (int k = 0; k < 32; k++) begin
      step(k == 31, 1'b0);
      w[k] = sTdo;
      enAll = enAll & sEn;
    end
    step(1'b1, 1'b0);   // Update-DR
    chk({tag, " enable off after shift"}, {31'b0, sEn}, 32'h0);
    step(1'b0, 1'b0);   // Run-Test/Idle
    gotWord  = w;
    gotEnAll = enAll;
    ->wordEv;
  endtask

  // Hold TRST low with one select value, change it just before the rise.
  task automatic newSession(input logic selLow, input logic selAtRise);
    @(negedge jtagTck);
    #1;
    jtagTrstN = 1'b0;
    tapSelPin = selLow;
    repeat (3) step(1'b0, 1'b1);
    chk("R7 tapTrstN low while TRST low", {30'b0, tapTrstN}, 32'h0);
    chk("R7 TDO disabled while TRST low", {31'b0, jtagTdoEn}, 32'h0);
    @(negedge jtagTck);
    #1;
    tapSelPin = selAtRise;
    #0.5;
    jtagTrstN = 1'b1;
    @(posedge jtagTck);
    #1;
  endtask

  // Monitor: pop the expected item when a word has been shifted out.
  initial begin
    exp_t e;
    forever begin
      @(wordEv);
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6: word seen with nothing expected got %h expected none", gotWord);
      end else begin
        e = expQ.pop_front();
        chk(e.tag, gotWord, e.id);
        chk({e.tag, " enable during shift"}, {31'b0, gotEnAll}, 32'h1);
      end
    end
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    jtagTrstN = 1'b0;
    jtagTms   = 1'b1;
    jtagTdi   = 1'b0;
    tapSelPin = 1'b1;
    repeat (4) @(posedge jtagTck);
    #1;
    chk("R7 reset tapTrstN", {30'b0, tapTrstN}, 32'h0);
    chk("R7 reset TDO enable", {31'b0, jtagTdoEn}, 32'h0);

    // Pulled-up select at the rise: emulation.
    @(negedge jtagTck);
    #1;
    jtagTrstN = 1'b1;
    @(posedge jtagTck);
    #1;
    chk("R3 idle-high select connects emulation", {30'b0, tapTrstN}, 32'h2);
    chk("R1 parked TMS high", {31'b0, tapTms[0]}, 32'h1);
    chk("R1 parked TDI high", {31'b0, tapTdi[0]}, 32'h1);
    readId(EMU_ID, "R3 R6 emulation code");

    // Shift-IR also enables the output.
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R6 enable in Shift-IR", {31'b0, sEn}, 32'h1);
    chk("R6 TDO from IR capture", {31'b0, sTdo}, 32'h1);
    step(1'b1, 1'b0);
    chk("R6 enable off outside shift", {31'b0, sEn}, 32'h0);
    step(1'b0, 1'b0);

    // Pass-through of TDI/TMS and clock.
    step(1'b0, 1'b1);
    chk("R5 TDI reaches connected TAP", {31'b0, tapTdi[1]}, 32'h1);
    chk("R5 TMS reaches connected TAP", {31'b0, tapTms[1]}, 32'h0);
    chk("R5 TCK to both TAPs high", {30'b0, tapTck}, 32'h3);
    step(1'b0, 1'b0);
    chk("R5 TDI low reaches connected TAP", {31'b0, tapTdi[1]}, 32'h0);
    chk("R1 parked TDI stays high", {31'b0, tapTdi[0]}, 32'h1);
    chk("R1 parked TAP stays in reset", {31'b0, tapInReset[0]}, 32'h1);

    // Select change mid-session is ignored.
    tapSelPin = 1'b0;
    repeat (3) step(1'b0, 1'b0);
    chk("R4 select change ignored", {30'b0, tapTrstN}, 32'h2);
    readId(EMU_ID, "R4 still emulation after select change");

    // New session with select low: boundary scan.
    newSession(1'b0, 1'b0);
    chk("R2 low select connects boundary scan", {30'b0, tapTrstN}, 32'h1);
    readId(BSC_ID, "R2 boundary-scan code");
    chk("R1 emulation TAP held in reset", {31'b0, tapInReset[1]}, 32'h1);
    chk("R1 emulation TMS held high", {31'b0, tapTms[1]}, 32'h1);
    tapSelPin = 1'b1;
    repeat (2) step(1'b1, 1'b0);
    chk("R4 raising select mid-session ignored", {30'b0, tapTrstN}, 32'h1);

    // Only the value at the rise counts.
    newSession(1'b0, 1'b1);
    chk("R2 value at rise wins", {30'b0, tapTrstN}, 32'h2);
    readId(EMU_ID, "R2 emulation after late select change");

    newSession(1'b1, 1'b0);
    chk("R2 value at rise wins low", {30'b0, tapTrstN}, 32'h1);
    readId(BSC_ID, "R2 boundary scan after late select change");

    repeat (4) step(1'b0, 1'b0);
    chk("R6 all expected words seen", expQ.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule